// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic running on a single clock read and write an external asynchronous static RAM of 512K bytes. The memory side has a 19-bit address, active-low chip select, output enable and write strobe, and an 8-bit data bus. The data bus is split into an input, an output and a drive enable, so that a pad cell at the chip edge can form the tri-state pin.

On the user side there is a request/ready handshake. A request is taken on a rising clock edge where `req` and `ready` are both high. It carries the address, the write data and a write flag. For a read, the byte comes back on `rd_data` together with a one-cycle `rd_valid` strobe.

All memory timing comes from counting clock cycles. The parameter `CLK_NS` gives the clock period in nanoseconds. Each minimum time in nanoseconds is turned into a cycle count by rounding up to whole cycles. These times cover:
- the read access time;
- the write strobe width;
- address setup to the end of a write;
- data setup to the end of a write;
- the full cycle time;
- the time the memory may keep driving the bus after it is deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, `ready`=1, `mem_ce_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A read (`wr`=0) drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high, and keeps them there for ceil(max(70,35)/CLK_NS) cycles. `rd_valid` goes high for exactly one cycle, that many cycles after the accept edge: 9 cycles at 8 ns.
- R3: The byte on `rd_data` while `rd_valid` is high equals the last byte written to that address.
- R4: A write (`wr`=1) holds `mem_we_n` and `mem_ce_n` low for max(ceil(55/T), ceil(60/T), ceil(30/T)+2) cycles, where T is `CLK_NS`. That is 8 cycles at 8 ns. `mem_oe_n` stays high whenever `mem_we_n` is low.
- R5: `mem_dq_oe` rises one cycle after `mem_we_n` falls and drops on the same edge where `mem_we_n` rises. The data is therefore stable for at least 30 ns before the write ends, and is never driven while the memory is deselected.
- R6: `mem_addr` does not change while `mem_we_n` is low.
- R7: `mem_dq_oe` stays low for at least ceil(25/T) cycles after `mem_oe_n` rises, which is 4 cycles at 8 ns.
- R8: `ready` drops on the accept edge. It returns after the cycle-time count is complete.
  - A write is busy for max(ceil(70/T), write strobe cycles + 1) cycles: 9 at 8 ns.
  - A read is busy for the read access count plus the release count: 13 at 8 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, taken when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (19) | Word address |
| wr_data | input | DATA_W (8) | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | DATA_W (8) | Byte read back |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| mem_addr | output | ADDR_W (19) | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | DATA_W (8) | Data toward the pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | DATA_W (8) | Data from the pad |

## Verification
The bench computes every latency from the nanosecond rules and an 8 ns clock.
- A read strobe is due 9 edges after the accept edge.
- A read leaves the controller busy for 13 edges.
- A write leaves the controller busy for 9 edges.

The bench drives and samples on falling edges and counts edges from acceptance. Each result is compared against the exact edge count at which it must first appear.

The memory model moves to its true data only once the access time has passed at the next sampling edge. It therefore returns a corrupted byte to any capture made one cycle too early. The model also measures strobe width, data setup, address hold and the bus release window per edge.

// File: rtl/sram_acc_pkg.sv
package sram_acc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WR,
      ST_WREC
   } acc_state_t;

   // Nanoseconds to whole clock cycles, rounding up.
   function automatic int ns2cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   // A load takes priority over counting down; the count stops at zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= cap;
         if (cap) begin
            rd_data <= dq_i;
         end
      end
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_acc_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 4,
   parameter int RD_CYC   = 9,
   parameter int TURN_CYC = 4,
   parameter int WE_CYC   = 8,
   parameter int REC_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ready,
   output logic              cap,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   input  logic              tmr_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

   acc_state_t state_q, state_d;

   assign ready = (state_q == ST_IDLE);
   assign cap   = (state_q == ST_RD) && tmr_done;

   // Next state, plus the timer reload for the phase being entered.
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (req) begin
            tmr_load = 1'b1;
            if (wr) begin
               state_d = ST_WR;
               tmr_val = WE_LD;
            end else begin
               state_d = ST_RD;
               tmr_val = RD_LD;
            end
         end
         ST_RD: if (tmr_done) begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = TURN_LD;
         end
         ST_TURN: if (tmr_done) state_d = ST_IDLE;
         ST_WR: if (tmr_done) begin
            state_d  = ST_WREC;
            tmr_load = 1'b1;
            tmr_val  = REC_LD;
         end
         ST_WREC: if (tmr_done) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   // Memory pins are all registered, so they change on clock edges only.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mem_addr  <= '0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_o  <= '0;
         mem_dq_oe <= 1'b0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_IDLE: if (req) begin
               mem_addr <= addr;
               mem_ce_n <= 1'b0;
               if (wr) begin
                  mem_we_n <= 1'b0;
                  mem_dq_o <= wr_data;
               end else begin
                  mem_oe_n <= 1'b0;
               end
            end
            ST_RD: if (tmr_done) begin
               mem_ce_n <= 1'b1;
               mem_oe_n <= 1'b1;
            end
            ST_WR: begin
               // Drive the bus one cycle into the strobe, and let go on the edge the strobe ends.
               mem_dq_oe <= !tmr_done;
               if (tmr_done) begin
                  mem_we_n <= 1'b1;
                  mem_ce_n <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_acc_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 8,
   parameter int CLK_NS     = 8,
   parameter int T_ACC_NS   = 70,
   parameter int T_OEACC_NS = 35,
   parameter int T_CYC_NS   = 70,
   parameter int T_WP_NS    = 55,
   parameter int T_AW_NS    = 60,
   parameter int T_DS_NS    = 30,
   parameter int DS_MARGIN  = 1,
   parameter int T_REL_NS   = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int RD_CYC   = imax(imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OEACC_NS, CLK_NS)),
                                  ns2cyc(T_CYC_NS, CLK_NS));
   localparam int TURN_CYC = imax(1, ns2cyc(T_REL_NS, CLK_NS));
   localparam int WE_CYC   = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                  1 + ns2cyc(T_DS_NS, CLK_NS) + DS_MARGIN);
   localparam int REC_CYC  = imax(1, ns2cyc(T_CYC_NS, CLK_NS) - WE_CYC);
   localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(WE_CYC, REC_CYC));
   localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

   if (ADDR_W < 1 || DATA_W < 1 || CLK_NS < 1 || DS_MARGIN < 0) begin : g_bad_cfg
      $error("sram_async_ctrl: widths and clock period must be positive");
   end

   logic             cap;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;

   sram_wait_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_seq_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .RD_CYC   (RD_CYC),
      .TURN_CYC (TURN_CYC),
      .WE_CYC   (WE_CYC),
      .REC_CYC  (REC_CYC)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wr        (wr),
      .addr      (addr),
      .wr_data   (wr_data),
      .ready     (ready),
      .cap       (cap),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .tmr_done  (tmr_done),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .dq_i     (mem_dq_i),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
   import sram_acc_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int CLK_NS    = 8,
   parameter int T_WP_NS   = 55,
   parameter int T_AW_NS   = 60,
   parameter int T_DS_NS   = 30,
   parameter int DS_MARGIN = 1,
   parameter int T_REL_NS  = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe
);

   localparam int WE_MIN  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                 1 + ns2cyc(T_DS_NS, CLK_NS) + DS_MARGIN);
   localparam int REL_MIN = imax(1, ns2cyc(T_REL_NS, CLK_NS));

   int we_lo_cnt;
   int oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= 0;
         oe_hi_cnt <= 255;
      end else begin
         we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
         if (!mem_oe_n)             oe_hi_cnt <= 0;
         else if (oe_hi_cnt < 255)  oe_hi_cnt <= oe_hi_cnt + 1;
      end
   end

   // R4
   oe_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   // R4
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= WE_MIN));

   // R5
   drive_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |=> mem_dq_oe);

   // R5
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_oe);

   // R5
   drive_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_ce_n && !mem_we_n));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

   // R7
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (oe_hi_cnt >= REL_MIN));

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .CLK_NS    (CLK_NS),
   .T_WP_NS   (T_WP_NS),
   .T_AW_NS   (T_AW_NS),
   .T_DS_NS   (T_DS_NS),
   .DS_MARGIN (DS_MARGIN),
   .T_REL_NS  (T_REL_NS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .ready     (ready),
   .rd_valid  (rd_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

   localparam int CLK_NS = 8;
   localparam int AW     = 19;
   localparam int DW     = 8;

   // Expected counts, worked out from the nanosecond rules.
   localparam int RD_LAT  = ((70 + CLK_NS - 1) / CLK_NS);
   localparam int REL_CYC = ((25 + CLK_NS - 1) / CLK_NS);
   localparam int RD_BUSY = RD_LAT + REL_CYC;
   localparam int WE_A    = ((60 + CLK_NS - 1) / CLK_NS);
   localparam int WE_B    = ((30 + CLK_NS - 1) / CLK_NS) + 2;
   localparam int WE_CYC  = (WE_A > WE_B) ? WE_A : WE_B;
   localparam int WC_CYC  = ((70 + CLK_NS - 1) / CLK_NS);
   localparam int WR_BUSY = (WC_CYC > WE_CYC + 1) ? WC_CYC : WE_CYC + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sram_async_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .req (req), .wr (wr), .addr (addr),
      .wr_data (wr_data), .ready (ready), .rd_data (rd_data), .rd_valid (rd_valid),
      .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
      .mem_we_n (mem_we_n), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
      .mem_dq_i (mem_dq_i)
   );

   // ---------------- memory model ----------------
   logic [DW-1:0] model_mem [logic [AW-1:0]];
   logic [DW-1:0] exp_mem   [logic [AW-1:0]];
   logic [DW-1:0] rd_byte;
   logic          model_drive;
   int            acc_cnt, rel_cnt, we_low, ds_cnt;
   logic [DW-1:0] last_d;
   logic [AW-1:0] wr_addr;
   int v_pulse = 0, v_setup = 0, v_addr = 0, v_cont = 0, v_oe = 0, v_dly = 0;

   assign model_drive = !mem_ce_n && !mem_oe_n && mem_we_n;

   always_comb begin
      rd_byte = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
   end

   // True data appears only once the access time has passed at the next edge.
   assign mem_dq_i = model_drive ? (((acc_cnt + 1) * CLK_NS >= 70) ? rd_byte : ~rd_byte)
                                 : (mem_dq_oe ? mem_dq_o : '0);

   always @(posedge clk) begin
      if (!rst_n) begin
         acc_cnt <= 0;
         rel_cnt <= 100;
         we_low  <= 0;
         ds_cnt  <= 0;
         last_d  <= '0;
         wr_addr <= '0;
      end else begin
         acc_cnt <= model_drive ? acc_cnt + 1 : 0;
         if (model_drive)        rel_cnt <= 0;
         else if (rel_cnt < 100) rel_cnt <= rel_cnt + 1;
         if (mem_dq_oe && (model_drive || rel_cnt * CLK_NS < 25)) v_cont++;
         if (!mem_ce_n && !mem_we_n) begin
            if (!mem_oe_n) v_oe++;
            if (we_low == 0) begin
               wr_addr <= mem_addr;
               if (mem_dq_oe) v_dly++;
            end else begin
               if (mem_addr != wr_addr) v_addr++;
               if (we_low == 1 && !mem_dq_oe) v_dly++;
            end
            we_low <= we_low + 1;
            if (mem_dq_oe) begin
               ds_cnt <= (ds_cnt > 0 && mem_dq_o == last_d) ? ds_cnt + 1 : 1;
               last_d <= mem_dq_o;
            end else begin
               ds_cnt <= 0;
            end
         end else if (we_low > 0) begin
            if (we_low * CLK_NS < 55 || we_low * CLK_NS < 60) v_pulse++;
            if (ds_cnt * CLK_NS < 30) v_setup++;
            model_mem[wr_addr] = last_d;
            we_low <= 0;
            ds_cnt <= 0;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int cyc, rv_at, rv_n;
      logic [DW-1:0] got;
      got = '0;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; wr = w; addr = a; wr_data = d;
      @(negedge clk);
      req = 1'b0;
      cyc = 0; rv_at = -1; rv_n = 0;
      while (!ready && cyc < 60) begin
         if (rd_valid) begin
            if (rv_n == 0) begin rv_at = cyc; got = rd_data; end
            rv_n++;
         end
         @(negedge clk);
         cyc++;
      end
      if (w) begin
         exp_mem[a] = d;
         // R8 write busy time
         check(cyc == WR_BUSY, "R8 write busy cycles", cyc, WR_BUSY);
      end else begin
         // R2 strobe position and width
         check(rv_at == RD_LAT, "R2 read strobe cycle", rv_at, RD_LAT);
         check(rv_n == 1, "R2 read strobe width", rv_n, 1);
         // R3 data
         check(got == exp_mem[a], "R3 read data", int'(got), int'(exp_mem[a]));
         // R8 read busy time (includes R7 release)
         check(cyc == RD_BUSY, "R8 read busy cycles", cyc, RD_BUSY);
      end
   endtask

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 150000);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
      check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes idle in reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
      check(mem_dq_oe == 1'b0 && rd_valid == 1'b0, "R1 drive and strobe off in reset",
            int'({mem_dq_oe, rd_valid}), 0);
      rst_n = 1'b1;

      // Corners: lowest and highest address, then a walking one over every address bit.
      do_op(1'b1, 19'h00000, 8'hA5);
      do_op(1'b1, 19'h7FFFF, 8'h5A);
      for (int b = 0; b < AW; b++) begin
         do_op(1'b1, 19'(1) << b, 8'(b * 13 + 7));
      end
      do_op(1'b0, 19'h00000, 8'h00);
      do_op(1'b0, 19'h7FFFF, 8'h00);
      for (int b = 0; b < AW; b++) begin
         do_op(1'b0, 19'(1) << b, 8'h00);
      end
      // Overwrite then read, and a read directly followed by a write (turnaround).
      do_op(1'b1, 19'h00000, 8'hFF);
      do_op(1'b0, 19'h00000, 8'h00);
      do_op(1'b1, 19'h00000, 8'h00);
      do_op(1'b0, 19'h00000, 8'h00);

      // Pseudo-random write-then-read pairs.
      for (int i = 0; i < 60; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         a = AW'(i * 40503 + 1237);
         d = DW'(i * 37 + 91);
         do_op(1'b1, a, d);
         do_op(1'b0, a, 8'h00);
      end

      repeat (4) @(negedge clk);
      // R4 strobe width and output enable during writes
      check(v_pulse == 0, "R4 write strobe width violations", v_pulse, 0);
      check(v_oe == 0, "R4 output enable low during write", v_oe, 0);
      // R5 drive delay and data setup
      check(v_dly == 0, "R5 drive enable timing violations", v_dly, 0);
      check(v_setup == 0, "R5 data setup violations", v_setup, 0);
      // R6 address hold
      check(v_addr == 0, "R6 address moved during write", v_addr, 0);
      // R7 bus release window
      check(v_cont == 0, "R7 bus contention events", v_cont, 0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule